// File: doc/BRIEF.md
# Bit-Serial Xorshift Word Generator

This block produces a repeatable stream of pseudorandom data words. Its usual job is to supply the contents of a read-only memory or a placeholder firmware image, so that separate builds share identical contents. A shift-and-XOR register advances by one step on every clock. Each output word is not a copy of that register: it is built from the lowest bit of the register after each of 32 consecutive steps.

A run begins on a start strobe, which loads the requested word count and resets the register to 1. One word is ready every 32 cycles and is announced by a one-cycle valid strobe. Each finished word becomes the register value from which the next word is generated, so the sequence chains from word to word. When the last word appears, the block drops busy and raises done in the same cycle. Done stays high until the next accepted start. A count of 2048 fills an 8 KiB region of 32-bit words.

Top module: `xorshift_word_gen`

## Requirements
- R1: One register step replaces x with x XOR (x shifted left 13), then that result XOR itself shifted right 17, then that result XOR itself shifted left 5, with each intermediate truncated to 32 bits.
- R2: An output word takes its bit i, for i from 0 to 31, from bit 0 of the register after step i of that word. Bit 0 is filled first and bit 31 last.
- R3: Every accepted start resets the register to 1, so every run produces the same first word.
- R4: After a word completes, the register is loaded with that word, and the next word's steps begin from it.
- R5: The block takes one step per clock. The first word_valid pulse comes 32 cycles after the clock edge that accepts start, and later pulses come every 32 cycles. Each pulse lasts exactly one cycle.
- R6: word_count is sampled only at the edge that accepts start. Exactly that many words are emitted. done rises, and busy falls, in the same cycle as the last word_valid.
- R7: A start with word_count equal to 0 raises done one cycle later, leaves busy low, and emits no word.
- R8: A start strobe while busy is high is ignored. The running sequence, its word count and its timing are unchanged.
- R9: After reset, busy, done and word_valid are 0 and word_data is 0. The block is idle, and its register is 1.
- R10: busy and done are never high together. Once done is high, it stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when idle |
| word_count | input | 16 | Number of words for the run, sampled at start |
| word_valid | output | 1 | One-cycle strobe when word_data holds a new word |
| word_data | output | 32 | Most recent completed word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |

## Verification
A wrong register value or a wrong bit index inside a word shows up on word_data at the very first word_valid, 32 cycles after start. Because each word seeds the next, the error then spreads into every later word. A chaining fault leaves the first word correct and breaks the second one, 64 cycles after start. A fault in the bit index or the word counter shows up as a pulse in the wrong cycle, or as done arriving early or late, within the run being checked.

// File: rtl/xsw_pkg.sv
package xsw_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;

  localparam int unsigned XSW_SHIFT_A = 13;
  localparam int unsigned XSW_SHIFT_B = 17;
  localparam int unsigned XSW_SHIFT_C = 5;
endpackage

// File: rtl/xsw_step.sv
module xsw_step #(
  parameter int unsigned W  = 32,
  parameter int unsigned SA = 13,
  parameter int unsigned SB = 17,
  parameter int unsigned SC = 5
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] x_o
);
  logic [W-1:0] mix_a;
  logic [W-1:0] mix_b;

  // three chained shift/xor stages, all truncated to W bits
  always_comb begin
    mix_a = x_i ^ (x_i << SA);
    mix_b = mix_a ^ (mix_a >> SB);
    x_o   = mix_b ^ (mix_b << SC);
  end
endmodule

// File: rtl/xsw_bit_packer.sv
module xsw_bit_packer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o,
  output logic         last_o
);
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W - 1);

  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]     acc_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      idx_q <= '0;
    end else if (step_i) begin
      if (idx_q == IDX_LAST) idx_q <= '0;
      else                   idx_q <= idx_q + 1'b1;
    end
  end

  // one capture flop per word bit; the current bit bypasses its flop
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear_i) begin
        acc_q[g] <= 1'b0;
      end else if (step_i && (idx_q == IDX_W'(g))) begin
        acc_q[g] <= bit_i;
      end
    end
    assign word_o[g] = (idx_q == IDX_W'(g)) ? bit_i : acc_q[g];
  end

  assign last_o = step_i && (idx_q == IDX_LAST);
endmodule

// File: rtl/xsw_word_counter.sv
module xsw_word_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= load_val_i;
    end else if (dec_i && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign last_o = (left_q == CNT_W'(1));
endmodule

// File: rtl/xorshift_word_gen.sv
module xorshift_word_gen
  import xsw_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEED   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  word_count,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              busy,
  output logic              done
);
  localparam logic [WORD_W-1:0] SEED_V = WORD_W'(SEED);

  run_state_t        st_q;
  logic [WORD_W-1:0] reg_q;
  logic [WORD_W-1:0] step_nxt;
  logic [WORD_W-1:0] word_nxt;
  logic              word_last;
  logic              cnt_last;
  logic              start_ok;
  logic              stepping;

  assign start_ok = start && (st_q == ST_IDLE);
  assign stepping = (st_q == ST_RUN);

  xsw_step #(
    .W (WORD_W),
    .SA(XSW_SHIFT_A),
    .SB(XSW_SHIFT_B),
    .SC(XSW_SHIFT_C)
  ) u_step (
    .x_i(reg_q),
    .x_o(step_nxt)
  );

  xsw_bit_packer #(.W(WORD_W)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .clear_i(start_ok),
    .step_i (stepping),
    .bit_i  (step_nxt[0]),
    .word_o (word_nxt),
    .last_o (word_last)
  );

  xsw_word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load_i    (start_ok),
    .load_val_i(word_count),
    .dec_i     (word_last),
    .last_o    (cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      reg_q      <= SEED_V;
      word_valid <= 1'b0;
      word_data  <= '0;
      done       <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (start_ok) begin
        reg_q <= SEED_V;
        if (word_count == '0) begin
          st_q <= ST_IDLE;
          done <= 1'b1;
        end else begin
          st_q <= ST_RUN;
          done <= 1'b0;
        end
      end else if (stepping) begin
        if (word_last) begin
          // finished word seeds the next word
          reg_q      <= word_nxt;
          word_data  <= word_nxt;
          word_valid <= 1'b1;
          if (cnt_last) begin
            st_q <= ST_IDLE;
            done <= 1'b1;
          end
        end else begin
          reg_q <= step_nxt;
        end
      end
    end
  end

  assign busy = (st_q == ST_RUN);
endmodule

// File: rtl/xorshift_word_gen_checker.sv
module xorshift_word_gen_checker #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CNT_W-1:0]  word_count,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic              busy,
  input logic              done
);
  localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [IDX_W-1:0] steps_q;

  always_ff @(posedge clk) begin
    if (rst)                 steps_q <= '0;
    else if (start && !busy) steps_q <= '0;
    else if (busy)           steps_q <= steps_q + 1'b1;
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  p_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (steps_q == '0));

  p_valid_busy_r5: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(busy));

  p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (word_count == '0)) |=> (done && !busy && !word_valid));

  p_done_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (word_valid || ($past(start) && ($past(word_count) == '0))));

  p_data_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(word_data));
endmodule

bind xorshift_word_gen xorshift_word_gen_checker #(
  .WORD_W(WORD_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .word_count(word_count),
  .word_valid(word_valid),
  .word_data (word_data),
  .busy      (busy),
  .done      (done)
);

// File: tb/xorshift_word_gen_bench.sv
module xorshift_word_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] word_count = 16'd0;
  logic        word_valid;
  logic [31:0] word_data;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xorshift_word_gen u_xorshift_word_gen (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .word_count(word_count),
    .word_valid(word_valid),
    .word_data (word_data),
    .busy      (busy),
    .done      (done)
  );

  function automatic logic [31:0] ref_step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] seed);
    logic [31:0] s;
    logic [31:0] w;
    s = seed;
    w = '0;
    for (int i = 0; i < 32; i++) begin
      s = ref_step(s);
      w[i] = s[0];
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // starts a run of n words; optionally pulses start again at cycle inject_at
  task automatic t_run(input int n, input int inject_at, input string req);
    logic [31:0] exp_w;
    int k;
    int cyc;
    bit fin;
    exp_w = 32'd1;
    k = 0;
    cyc = 0;
    fin = 0;
    @(negedge clk);
    start = 1'b1;
    word_count = 16'(n);
    @(posedge clk); #1;
    start = 1'b0;
    word_count = 16'd3;  // R6: changes after start must not matter
    check(busy == 1'b1 && done == 1'b0, req, "busy after start", {30'd0, busy, done}, 32'd2);
    while (!fin && cyc < 32 * n + 40) begin
      if (inject_at > 0 && cyc == inject_at) begin
        start = 1'b1;
        word_count = 16'd9;
      end
      @(posedge clk); #1;
      start = 1'b0;
      cyc++;
      if (word_valid) begin
        exp_w = ref_word(exp_w);
        check(cyc == 32 * (k + 1), "R5", "word_valid cycle", 32'(cyc), 32'(32 * (k + 1)));
        check(word_data == exp_w, "R1 R2 R4", "word value", word_data, exp_w);
        k++;
        if (k == n)
          check(done && !busy, "R6", "done with last word", {30'd0, busy, done}, 32'd1);
      end
      if (done) fin = 1;
    end
    check(k == n, req, "words emitted", 32'(k), 32'(n));
    @(posedge clk); #1;
    check(!word_valid, "R5", "pulse one cycle", {31'd0, word_valid}, 32'd0);
  endtask

  task automatic t_reset_state();
    check(!busy && !done && !word_valid && word_data == 32'd0, "R9", "reset outputs",
          {word_data[28:0], busy, done, word_valid}, 32'd0);
  endtask

  task automatic t_zero_count();
    int pulses;
    pulses = 0;
    @(negedge clk);
    start = 1'b1;
    word_count = 16'd0;
    @(posedge clk); #1;
    start = 1'b0;
    check(done && !busy, "R7", "zero count done", {30'd0, busy, done}, 32'd1);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (word_valid) pulses++;
    end
    check(pulses == 0, "R7", "no words for zero count", 32'(pulses), 32'd0);
  endtask

  task automatic t_done_hold();
    bit held;
    held = 1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (!done || busy || word_valid) held = 0;
    end
    check(held, "R10", "done holds while idle", {31'd0, held}, 32'd1);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    start = 1'b1;
    word_count = 16'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (45) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset_state();
    t_run(2, 0, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset_state();
    t_run(1, 0, "R2");
    t_run(3, 0, "R4");
    t_done_hold();
    t_run(2, 0, "R3");
    t_run(3, 40, "R8");
    t_run(2, 63, "R8");
    t_zero_count();
    t_mid_reset();
    t_run(2048, 0, "R6");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule